// File: doc/BRIEF.md
# Stack-Relative Register File with Frame Spill and Refill

This block holds a processor's registers as a stack addressed downward from a moving stack pointer. Every register number the core presents is an offset from that pointer. Offset 0 is always the status word and offset 1 is always the program counter, so both slots move whenever the frame moves. Four operations move the frame:

- **push** creates one general register.
- **call** creates one register and leaves the caller's PC at offset 2.
- **interrupt** entry creates two registers and leaves the old status at offset 2 and the old PC at offset 3.
- **return** and **interrupt return** undo a call and an interrupt.

A circular buffer of `N` physical entries holds the youngest part of the stack. The stack pointer grows toward lower positions, so the oldest registers sit at the highest positions. When a frame-growing operation would overflow the buffer, the four oldest entries are written to memory as one aligned 256-bit group. When a shrinking operation would leave fewer than four registers resident, the group just above the resident window is read back first. During either transfer `busy` is high and the pending operation waits. The core holds `op_valid` and the operation fields until a cycle in which `busy` is low. The operation completes on that clock edge.

Two combinational read ports and one write port serve the datapath every cycle.

Top module: `regstack_frame`

## Requirements
- R1: After reset, `sp` equals `RESET_SP` and `busy` and `mem_req` are low. Offsets 0 to 3 read zero, and four registers are resident.
- R2: Offsets 0 up to the resident count minus one are readable on both read ports. A write with `wr_en` lands at offset `wr_off` of the current frame. A read of the offset being written in the same cycle returns `wr_data`.
- R3: A push (`op_kind` 0) lowers `sp` by one. The new offset 0 holds the old status and the new offset 1 holds the old PC. The new offset k+1 holds the old offset k for k of 1 and above.
- R4: A call (`op_kind` 1) lowers `sp` by one. The new offset 0 holds the old status, the new offset 1 holds `op_pc`, and the new offset k+1 holds the old offset k for k of 1 and above, so the caller's PC is at offset 2.
- R5: An interrupt (`op_kind` 2) lowers `sp` by two. The new offset 0 holds `op_sr`, offset 1 holds `op_pc`, offset 2 holds the old status and offset 3 holds the old PC.
- R6: A return (`op_kind` 3) raises `sp` by one. The new offset 0 holds the old status, and the new offset k holds the old offset k+1 for k of 1 and above.
- R7: An interrupt return (`op_kind` 4) raises `sp` by two. The new offset k holds the old offset k+2.
- R8: A push or call arriving with `N` resident registers, or an interrupt arriving with `N`-1 or more, first spills the oldest four. The spill is one write with group address equal to (highest resident position minus 3) shifted right by 2. Word j of `mem_wdata` (bits 64j and up) is position 4·group+j. The resident count then drops by four, and `busy` stays high and `sp` stays unchanged until the operation can complete.
- R9: A return arriving with 4 or fewer resident registers, or an interrupt return with 5 or fewer, first reads the group just above the resident window. The data is taken from the group address in the same word order as R8, and the resident count rises by four before the operation completes.
- R10: Once `mem_req` is raised, it stays high with `mem_addr` and `mem_we` unchanged until the cycle `mem_ack` is seen.
- R11: A register write presented while `busy` is high has no effect.
- R12: `op_kind` values 5 to 7 leave `sp` and every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Frame operation present, held until a cycle with busy low |
| op_kind | input | 3 | 0 push, 1 call, 2 interrupt, 3 return, 4 interrupt return |
| op_pc | input | 64 | New PC for call and interrupt |
| op_sr | input | 64 | New status for interrupt |
| busy | output | 1 | Transfer in progress or pending operation must wait |
| sp | output | 16 | Current stack pointer (absolute position) |
| rd_a_off | input | 4 | Offset for read port A |
| rd_a_data | output | 64 | Read port A data |
| rd_b_off | input | 4 | Offset for read port B |
| rd_b_data | output | 64 | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_off | input | 4 | Register write offset |
| wr_data | input | 64 | Register write data |
| mem_req | output | 1 | Memory group transfer request |
| mem_we | output | 1 | 1 for spill (write), 0 for refill (read) |
| mem_addr | output | 14 | Group address (position divided by 4) |
| mem_wdata | output | 256 | Spill data, four words |
| mem_rdata | input | 256 | Refill data, four words |
| mem_ack | input | 1 | Transfer complete, one-cycle pulse |

## Verification
The hardest situation to reach is a return sequence that climbs above every group spilled earlier and past the reset frame. That climb needs refills of data written long before, interleaved with frames whose status and PC slots were rewritten after each operation. The bench first drives a long descending chain of mixed pushes, calls and interrupts so that many groups are spilled. It then unwinds with alternating returns and interrupt returns until refills come from groups never written. Every register write attempted during a spill lands on offset 1, which a later frame check would expose if it were honoured.

// File: rtl/regstack_frame.sv
module regstack_frame #(
  parameter int W = 64,
  parameter int N = 16,
  parameter int SPW = 16,
  parameter logic [SPW-1:0] RESET_SP = SPW'(256)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid,
  input  logic [2:0]         op_kind,
  input  logic [W-1:0]       op_pc,
  input  logic [W-1:0]       op_sr,
  output logic               busy,
  output logic [SPW-1:0]     sp,
  input  logic [$clog2(N)-1:0] rd_a_off,
  output logic [W-1:0]       rd_a_data,
  input  logic [$clog2(N)-1:0] rd_b_off,
  output logic [W-1:0]       rd_b_data,
  input  logic               wr_en,
  input  logic [$clog2(N)-1:0] wr_off,
  input  logic [W-1:0]       wr_data,
  output logic               mem_req,
  output logic               mem_we,
  output logic [SPW-3:0]     mem_addr,
  output logic [4*W-1:0]     mem_wdata,
  input  logic [4*W-1:0]     mem_rdata,
  input  logic               mem_ack
);
  localparam int OW = $clog2(N);
  localparam int GW = SPW - 2;
  localparam logic [2:0] K_PUSH = 3'd0, K_CALL = 3'd1, K_INT = 3'd2, K_RET = 3'd3, K_IRET = 3'd4;
  localparam logic [SPW-1:0] D_FULL = SPW'(N);
  localparam logic [SPW-1:0] D_NEAR = SPW'(N - 1);
  localparam logic [SPW-1:0] D_MIN1 = SPW'(4);
  localparam logic [SPW-1:0] D_MIN2 = SPW'(5);

  typedef enum logic [1:0] {S_IDLE, S_SPILL, S_FILL} st_t;

  function automatic logic [OW-1:0] wrap(input logic [OW-1:0] a, input int k);
    int s;
    s = int'(a) + k;
    if (s >= N) s = s - N;
    if (s < 0) s = s + N;
    return OW'(s);
  endfunction

  logic [W-1:0]   rf [N];
  logic [SPW-1:0] sp_q, hi_q;
  logic [OW-1:0]  spp_q, hip_q;
  st_t            st;

  logic [SPW-1:0] depth;
  logic grow1, grow2, shr1, shr2, need_spill, need_fill, go, wr_ok;

  assign depth = hi_q - sp_q;
  assign grow1 = (op_kind == K_PUSH) || (op_kind == K_CALL);
  assign grow2 = (op_kind == K_INT);
  assign shr1  = (op_kind == K_RET);
  assign shr2  = (op_kind == K_IRET);
  assign need_spill = op_valid && ((grow1 && depth >= D_FULL) || (grow2 && depth >= D_NEAR));
  assign need_fill  = op_valid && ((shr1 && depth <= D_MIN1) || (shr2 && depth <= D_MIN2));
  assign busy  = (st != S_IDLE) || need_spill || need_fill;
  assign go    = op_valid && !busy;
  assign wr_ok = wr_en && !busy;
  assign sp    = sp_q;

  assign rd_a_data = (wr_ok && wr_off == rd_a_off) ? wr_data : rf[wrap(spp_q, int'(rd_a_off))];
  assign rd_b_data = (wr_ok && wr_off == rd_b_off) ? wr_data : rf[wrap(spp_q, int'(rd_b_off))];

  assign mem_req  = (st != S_IDLE);
  assign mem_we   = (st == S_SPILL);
  assign mem_addr = (st == S_SPILL) ? hi_q[SPW-1:2] - GW'(1) : hi_q[SPW-1:2];

  for (genvar j = 0; j < 4; j++) begin : g_word
    assign mem_wdata[j*W +: W] = rf[wrap(hip_q, j - 4)];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q  <= RESET_SP;
      hi_q  <= RESET_SP + SPW'(4);
      spp_q <= '0;
      hip_q <= OW'(4);
      st    <= S_IDLE;
      for (int i = 0; i < N; i++) rf[i] <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (need_spill) st <= S_SPILL;
          else if (need_fill) st <= S_FILL;
        end
        S_SPILL: if (mem_ack) begin
          hi_q  <= hi_q - SPW'(4);
          hip_q <= wrap(hip_q, -4);
          st    <= S_IDLE;
        end
        S_FILL: if (mem_ack) begin
          for (int j = 0; j < 4; j++) rf[wrap(hip_q, j)] <= mem_rdata[j*W +: W];
          hi_q  <= hi_q + SPW'(4);
          hip_q <= wrap(hip_q, 4);
          st    <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
      if (wr_ok) rf[wrap(spp_q, int'(wr_off))] <= wr_data;
      if (go) begin
        case (op_kind)
          K_PUSH: begin
            rf[wrap(spp_q, -1)] <= rf[spp_q];
            rf[spp_q] <= rf[wrap(spp_q, 1)];
            sp_q  <= sp_q - SPW'(1);
            spp_q <= wrap(spp_q, -1);
          end
          K_CALL: begin
            rf[wrap(spp_q, -1)] <= rf[spp_q];
            rf[spp_q] <= op_pc;
            sp_q  <= sp_q - SPW'(1);
            spp_q <= wrap(spp_q, -1);
          end
          K_INT: begin
            rf[wrap(spp_q, -2)] <= op_sr;
            rf[wrap(spp_q, -1)] <= op_pc;
            sp_q  <= sp_q - SPW'(2);
            spp_q <= wrap(spp_q, -2);
          end
          K_RET: begin
            rf[wrap(spp_q, 1)] <= rf[spp_q];
            sp_q  <= sp_q + SPW'(1);
            spp_q <= wrap(spp_q, 1);
          end
          K_IRET: begin
            sp_q  <= sp_q + SPW'(2);
            spp_q <= wrap(spp_q, 2);
          end
          default: ;
        endcase
      end
    end
  end

  AST_DEPTH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    depth >= D_MIN1 && depth <= D_FULL); // R9
  AST_GROW1_SP: assert property (@(posedge clk) disable iff (!rst_n)
    go && grow1 |=> sp_q == $past(sp_q) - SPW'(1)); // R3
  AST_INT_SP: assert property (@(posedge clk) disable iff (!rst_n)
    go && grow2 |=> sp_q == $past(sp_q) - SPW'(2)); // R5
  AST_IRET_SP: assert property (@(posedge clk) disable iff (!rst_n)
    go && shr2 |=> sp_q == $past(sp_q) + SPW'(2)); // R7
  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(sp_q)); // R8
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R10
  AST_GROUP_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> hi_q[1:0] == 2'b00); // R8
endmodule

// File: tb/regstack_frame_test.sv
`timescale 1ns/100ps
module regstack_frame_test;
  logic clk = 0, rst_n = 0;
  logic op_valid = 0;
  logic [2:0] op_kind = 0;
  logic [63:0] op_pc = 0, op_sr = 0;
  logic busy;
  logic [15:0] sp;
  logic [3:0] rd_a_off = 0, rd_b_off = 0, wr_off = 0;
  logic [63:0] rd_a_data, rd_b_data, wr_data = 0;
  logic wr_en = 0;
  logic mem_req, mem_we, mem_ack = 0;
  logic [13:0] mem_addr;
  logic [255:0] mem_wdata, mem_rdata = 0;

  regstack_frame uut (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .op_pc(op_pc), .op_sr(op_sr), .busy(busy), .sp(sp), .rd_a_off(rd_a_off),
    .rd_a_data(rd_a_data), .rd_b_off(rd_b_off), .rd_b_data(rd_b_data), .wr_en(wr_en),
    .wr_off(wr_off), .wr_data(wr_data), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack));

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  int msp = 256, md = 4, exp_spill = 0, exp_fill = 0, got_spill = 0, got_fill = 0;
  logic [63:0] refm [0:511];
  logic [255:0] mem [0:127];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  int cnt = 0;
  logic pend = 0, pwe = 0;
  logic [13:0] paddr = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack <= 0; pend <= 0; cnt <= 0;
    end else if (mem_ack) begin
      mem_ack <= 0; pend <= 0;
    end else if (mem_req) begin
      if (pend) begin
        chk("R10 addr held", 64'(mem_addr), 64'(paddr));
        chk("R10 dir held", 64'(mem_we), 64'(pwe));
      end
      pend <= 1; paddr <= mem_addr; pwe <= mem_we;
      if (cnt == 2) begin
        cnt <= 0;
        mem_ack <= 1;
        if (mem_we) begin
          got_spill++;
          for (int j = 0; j < 4; j++)
            chk("R8 spill word", mem_wdata[j*64 +: 64], refm[(int'(mem_addr)*4 + j) & 511]);
          mem[mem_addr[6:0]] <= mem_wdata;
        end else begin
          got_fill++;
          mem_rdata <= mem[mem_addr[6:0]];
        end
      end else cnt <= cnt + 1;
    end
  end

  task automatic check_frame(input string req);
    @(negedge clk); #0.5;
    chk({req, " sp"}, 64'(sp), 64'(msp));
    for (int k = 0; k < md; k++) begin
      @(negedge clk);
      rd_a_off = 4'(k);
      rd_b_off = 4'(md - 1 - k);
      #0.5;
      chk(req, rd_a_data, refm[(msp + k) & 511]);
      chk(req, rd_b_data, refm[(msp + md - 1 - k) & 511]);
    end
  endtask

  task automatic wr_reg(input int off, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1; wr_off = 4'(off); wr_data = d; rd_a_off = 4'(off);
    #0.5;
    chk("R2 bypass", rd_a_data, d);
    @(posedge clk); #0.5;
    wr_en = 0;
    refm[(msp + off) & 511] = d;
  endtask

  task automatic do_op(input logic [2:0] k, input logic [63:0] pc, input logic [63:0] sr, input string req);
    bit sp_need, fl_need;
    sp_need = ((k == 0 || k == 1) && md >= 16) || (k == 2 && md >= 15);
    fl_need = (k == 3 && md <= 4) || (k == 4 && md <= 5);
    if (sp_need) begin md -= 4; exp_spill++; end
    if (fl_need) begin md += 4; exp_fill++; end
    @(negedge clk);
    op_valid = 1; op_kind = k; op_pc = pc; op_sr = sr;
    #0.5;
    if (sp_need) chk("R8 busy", 64'(busy), 64'(1));
    if (fl_need) chk("R9 busy", 64'(busy), 64'(1));
    while (busy) begin
      wr_en = 1; wr_off = 4'd1; wr_data = 64'hDEAD_BEEF_0000_0000 | 64'(checks);
      @(negedge clk);
      wr_en = 0;
      #0.5;
    end
    @(posedge clk); #0.5;
    op_valid = 0;
    case (k)
      3'd0: begin refm[(msp-1)&511] = refm[msp&511]; refm[msp&511] = refm[(msp+1)&511]; msp -= 1; md += 1; end
      3'd1: begin refm[(msp-1)&511] = refm[msp&511]; refm[msp&511] = pc; msp -= 1; md += 1; end
      3'd2: begin refm[(msp-2)&511] = sr; refm[(msp-1)&511] = pc; msp -= 2; md += 2; end
      3'd3: begin refm[(msp+1)&511] = refm[msp&511]; msp += 1; md -= 1; end
      3'd4: begin msp += 2; md -= 2; end
      default: ;
    endcase
    check_frame(req);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 512; i++) refm[i] = '0;
    for (int i = 0; i < 128; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1;
    #0.5;
    chk("R1 busy", 64'(busy), 64'(0));
    chk("R1 mem_req", 64'(mem_req), 64'(0));
    check_frame("R1");
    for (int i = 0; i < 4; i++) wr_reg(i, 64'h1111_0000_0000_0000 + 64'(i));
    check_frame("R2");
    for (int i = 0; i < 36; i++) begin
      logic [2:0] k;
      k = 3'(i % 3);
      do_op(k, 64'h2000 + 64'(i), 64'h5000 + 64'(i), k == 0 ? "R3" : (k == 1 ? "R4" : "R5"));
      wr_reg(0, 64'hA000 + 64'(i));
      wr_reg(2 + (i % 2), 64'hC000 + 64'(i));
    end
    do_op(3'd6, 64'h77, 64'h88, "R12 kind6");
    do_op(3'd7, 64'h77, 64'h88, "R12 kind7");
    do_op(3'd5, 64'h77, 64'h88, "R12 kind5");
    for (int i = 0; i < 44; i++) begin
      logic [2:0] k;
      k = (i % 2 == 0) ? 3'd3 : 3'd4;
      do_op(k, 64'h0, 64'h0, k == 3 ? "R6" : "R7");
      if (i % 5 == 0) wr_reg(1, 64'hE000 + 64'(i));
    end
    checks++; if (got_spill != exp_spill) begin fails++; $display("FAIL R8 spill count: actual %0d expected %0d", got_spill, exp_spill); end
    checks++; if (got_fill != exp_fill) begin fails++; $display("FAIL R9 fill count: actual %0d expected %0d", got_fill, exp_fill); end
    checks++; if (exp_spill == 0) begin fails++; $display("FAIL R11 spill never reached: actual 0 expected >0"); end
    finish_run();
  end
endmodule